// File: doc/BRIEF.md
# 64-bit Arithmetic Right Shifter with Lost-Ones Carry

This block performs a signed (sign-filling) right shift of a 64-bit operand for the integer execute stage of a RISC pipeline. The shift distance comes from a second 64-bit operand. Only its seven least-significant bits count. Distances of 64 or more saturate the result to all copies of the sign bit. Alongside the result it produces a carry flag. The carry is set when a negative operand loses one or more 1 bits off its low end. A following add-to-zero step can use that flag to turn floor rounding into truncation toward zero.

When the record flag of an operation is set, the block also produces a 4-bit condition field from a signed compare of the result against zero. It raises a write strobe for that field at the same time. The incoming summary-overflow bit is copied into the field and is never altered. All outputs are registered. An operation presented with `in_valid` high appears one clock later, marked by `out_valid`.

Top module: `sra64_unit`

## Requirements
- R1: The shift count is the 7 least-significant bits of `shamt` (`shamt[6:0]`). Every bit of `shamt[63:7]` has no effect on any output.
- R2: For a count n from 1 to 63, `result` equals `src_a` shifted right by n, with the n vacated high bits equal to `src_a[63]`.
- R3: For a count from 64 to 127, every bit of `result` equals `src_a[63]`.
- R4: For a count from 64 to 127, `carry` equals `src_a[63]`.
- R5: For a count of 0, `result` equals `src_a` and `carry` is 0.
- R6: For a count n from 1 to 63, `carry` is 1 exactly when `src_a[63]` is 1 and at least one of `src_a[n-1:0]` is 1.
- R7: `carry` is produced for every operation, with `rec_en` either 0 or 1.
- R8: With `rec_en` = 1, `cr_we` is 1 and `cr_field` holds the following bits, compared against zero as a signed 64-bit value:
  - bit 3: result less than zero
  - bit 2: result greater than zero
  - bit 1: result equal to zero
  - bit 0: a copy of `so_in`
- R9: With `rec_en` = 0, `cr_field` is 4'b0000 and `cr_we` is 0.
- R10: Outputs appear one clock after the operation is presented. `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Synchronous reset clears `out_valid`, `result`, `carry`, `cr_field` and `cr_we` to 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_a | input | 64 | Operand to shift |
| shamt | input | 64 | Shift-amount operand; low 7 bits used |
| rec_en | input | 1 | Record flag: request condition field |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Registered outputs hold a new operation |
| result | output | 64 | Sign-filled shift result |
| carry | output | 1 | Ones lost from a negative operand |
| cr_field | output | 4 | {LT, GT, EQ, SO} condition field |
| cr_we | output | 1 | Condition field write strobe |

## Verification
Operands cover three groups:
- positive values;
- -1 and the most negative value;
- negative values whose low bits are all zero.

The third group separates a carry taken from the sign alone from one that depends on the bits shifted out. Counts 0, 1, 63, 64 and 127 probe the pass-through case, each edge of the normal shift range and the saturated range. Counts whose upper `shamt` bits are set show whether the count extraction stops at bit 6. Each pattern is run with the record flag both set and clear, and with `so_in` at both levels. This exposes a compare that is mis-signed, that ignores the flag, or that loses the copied bit.

// File: rtl/sra64_pkg.sv
package sra64_pkg;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 7;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_field_t;
endpackage

// File: rtl/sra_count_decode.sv
module sra_count_decode #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 7
) (
  input  logic [DATA_W-1:0] shamt,
  output logic [CNT_W-1:0]  cnt,
  output logic              sat,
  output logic [DATA_W-1:0] lost_mask
);
  // only the low count bits take part; the rest are folded into an ignored net
  logic unused_hi;
  assign unused_hi = ^shamt[DATA_W-1:CNT_W];

  assign cnt = shamt[CNT_W-1:0];
  assign sat = ({{(32-CNT_W){1'b0}}, cnt} >= 32'(DATA_W));

  // mask of the bit positions that leave the low end; all ones once saturated
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign lost_mask[i] = sat | ({{(32-CNT_W){1'b0}}, cnt} > 32'(i));
  end
endmodule

// File: rtl/sra_shift_core.sv
module sra_shift_core #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         src,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic                      sat,
  output logic [DATA_W-1:0]         dout
);
  localparam int LOG_W = $clog2(DATA_W);

  logic               sign;
  logic [DATA_W-1:0]  stage [0:LOG_W];

  assign sign     = src[DATA_W-1];
  assign stage[0] = src;

  // logarithmic barrel: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < LOG_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{sign}}, stage[k][DATA_W-1:SH]} : stage[k];
  end

  assign dout = sat ? {DATA_W{sign}} : stage[LOG_W];
endmodule

// File: rtl/sra_cr_gen.sv
module sra_cr_gen
  import sra64_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res,
  input  logic              rec,
  input  logic              so_in,
  output cr_field_t         cr,
  output logic              we
);
  logic neg, zero;
  assign neg  = res[DATA_W-1];
  assign zero = (res == '0);

  always_comb begin
    cr = '0;
    if (rec) begin
      cr.lt = neg;
      cr.gt = !neg && !zero;
      cr.eq = zero;
      cr.so = so_in;
    end
  end
  assign we = rec;
endmodule

// File: rtl/sra64_unit.sv
module sra64_unit
  import sra64_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] shamt,
  input  logic          rec_en,
  input  logic          so_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic [3:0]    cr_field,
  output logic          cr_we
);
  localparam int LOG_W = $clog2(DW);

  logic [CW-1:0] cnt;
  logic          sat;
  logic [DW-1:0] lost_mask;
  logic [DW-1:0] shifted;
  logic          carry_d;
  cr_field_t     cr_d;
  logic          we_d;

  sra_count_decode #(.DATA_W(DW), .CNT_W(CW)) u_dec (
    .shamt(shamt), .cnt(cnt), .sat(sat), .lost_mask(lost_mask)
  );

  sra_shift_core #(.DATA_W(DW)) u_shift (
    .src(src_a), .amt(cnt[LOG_W-1:0]), .sat(sat), .dout(shifted)
  );

  // lost ones: negative operand with any masked low bit set
  assign carry_d = src_a[DW-1] & |(src_a & lost_mask);

  sra_cr_gen #(.DATA_W(DW)) u_cr (
    .res(shifted), .rec(rec_en), .so_in(so_in), .cr(cr_d), .we(we_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      cr_field  <= '0;
      cr_we     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      cr_we     <= in_valid & we_d;
      if (in_valid) begin
        result   <= shifted;
        carry    <= carry_d;
        cr_field <= cr_d;
      end
    end
  end

  // R5: zero count passes the operand through with carry clear
  p_zero_count_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt[CW-1:0] == '0) |=> (result == $past(src_a) && !carry));

  // R3 / R4: saturated counts give all-sign result and sign carry
  p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt[CW-1]) |=>
      (result == {DW{$past(src_a[DW-1])}} && carry == $past(src_a[DW-1])));

  // R6: a non-negative operand never reports lost ones
  p_pos_no_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !src_a[DW-1]) |=> !carry);

  // R9: record flag clear keeps the field and strobe low
  p_no_record_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rec_en) |=> (!cr_we && cr_field == 4'b0000));

  // R8: exactly one of LT/GT/EQ when the field is written
  p_cr_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr_field[3:1]) == 1));

  // R10: valid follows input valid by one cycle
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

// File: tb/tb_sra64_unit.sv
module tb_sra64_unit;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [63:0] src_a = '0;
  logic [63:0] shamt = '0;
  logic        rec_en = 0;
  logic        so_in = 0;
  logic        out_valid;
  logic [63:0] result;
  logic        carry;
  logic [3:0]  cr_field;
  logic        cr_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [63:0] res;
    logic        ca;
    logic [3:0]  cr;
    logic        we;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  sra64_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .shamt(shamt),
    .rec_en(rec_en), .so_in(so_in), .out_valid(out_valid), .result(result),
    .carry(carry), .cr_field(cr_field), .cr_we(cr_we)
  );

  function automatic exp_t model(input logic [63:0] a, input logic [63:0] b,
                                 input logic rec, input logic so, input string tag);
    exp_t e;
    int n;
    logic lost;
    n = int'(b[6:0]);
    lost = 1'b0;
    if (n >= 64) e.res = {64{a[63]}};
    else         e.res = 64'($signed(a) >>> n);
    for (int i = 0; i < 64; i++) if (i < n && a[i]) lost = 1'b1;
    e.ca  = a[63] & lost;
    e.we  = rec;
    e.cr  = rec ? {e.res[63], !e.res[63] && e.res != 0, e.res == 0, so} : 4'b0;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b,
                       input logic rec, input logic so, input string tag);
    @(negedge clk);
    in_valid = 1; src_a = a; shamt = b; rec_en = rec; so_in = so;
    sb.push_back(model(a, b, rec, so, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; src_a = 64'hDEAD_BEEF_0000_1234; shamt = 64'd3; rec_en = 1;
  endtask

  // monitor: compare each produced result against the queued expectation
  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected out_valid: act=1 exp=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result !== e.res || carry !== e.ca || cr_field !== e.cr || cr_we !== e.we) begin
          fails++;
          $display("FAIL %s: act res=%h ca=%b cr=%b we=%b exp res=%h ca=%b cr=%b we=%b",
                   e.tag, result, carry, cr_field, cr_we, e.res, e.ca, e.cr, e.we);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] MIN_NEG = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ALL1    = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] POSV    = 64'h1234_5678_9ABC_DEF1;
  localparam logic [63:0] NEGV    = 64'hF000_0000_0000_0100;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || result !== 0 || carry !== 0 || cr_field !== 0 || cr_we !== 0) begin
      fails++;
      $display("FAIL R10 reset state: act v=%b res=%h ca=%b cr=%b we=%b exp all zero",
               out_valid, result, carry, cr_field, cr_we);
    end
    @(negedge clk); rst = 0;

    // R5 zero count
    drive(NEGV, 64'd0, 1, 0, "R5 count0 neg");
    drive(POSV, 64'd0, 0, 1, "R5 count0 pos");
    // R2 / R6 normal range
    drive(ALL1, 64'd1, 1, 1, "R2 R6 minus1 by1");
    drive(MIN_NEG, 64'd1, 1, 0, "R2 R6 minneg by1");
    drive(MIN_NEG, 64'd63, 1, 0, "R2 R6 minneg by63");
    drive(POSV, 64'd63, 1, 0, "R2 pos by63");
    drive(POSV, 64'd4, 1, 0, "R2 pos by4");
    drive(NEGV, 64'd8, 1, 1, "R6 neg no lost ones");
    drive(NEGV, 64'd9, 1, 1, "R6 neg lost one");
    // R3 / R4 saturation
    drive(NEGV, 64'd64, 1, 0, "R3 R4 neg count64");
    drive(POSV, 64'd127, 1, 0, "R3 R4 pos count127");
    drive(MIN_NEG, 64'd127, 1, 1, "R3 R4 minneg count127");
    drive(64'd0, 64'd64, 1, 0, "R3 zero count64");
    // R1 upper bits ignored
    drive(NEGV, 64'hFFFF_FFFF_FFFF_FF89, 1, 0, "R1 upper bits count9");
    drive(POSV, 64'h8000_0000_0000_0000, 1, 0, "R1 upper bits count0");
    drive(NEGV, 64'h0000_0001_0000_0040, 0, 0, "R1 upper bits count64");
    // R7 carry without record, R9 record clear
    drive(ALL1, 64'd5, 0, 1, "R7 R9 carry no record");
    drive(MIN_NEG, 64'd70, 0, 1, "R7 R9 sat no record");
    // R8 flag variants
    drive(64'd1, 64'd1, 1, 1, "R8 eq with so");
    drive(64'd2, 64'd1, 1, 0, "R8 gt");
    idle();
    // R10: an idle cycle must not raise out_valid
    @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle cycle: act=%b exp=0", out_valid);
    end
    drive(ALL1, 64'd200, 1, 0, "R1 R3 count72 via wrap");
    idle();
    repeat (4) @(posedge clk);
    #2;
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R10 results missing: act=%0d pending exp=0", sb.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule